// File: doc/BRIEF.md
# Retimed Quadrature Reference Divider

This block divides a reference clock by 128 and produces two square waves that are a quarter period apart. It is meant to drive a pair of analog filters. The sine-like signals those filters produce are later sampled on an external timing pulse to interpolate phase. Everything runs on the reference clock, so no clock is generated from a data signal.

A synchronous prescaler divides the reference by 32 and gives a 50% duty square wave. One flip-flop on the reference clock retimes that wave. A rising-edge detector on the retimed wave produces a one-cycle step enable for a two-bit twisted-ring counter. The counter divides by four more, and its two state bits are the in-phase and quadrature outputs.

A synchronous reset returns the whole chain to a known phase. An enable freezes the chain. A one-cycle strobe marks each return of the ring counter to its starting state, which happens once per 128 enabled reference cycles. Neither output is a data stream, so every pin is a plain control or status signal with no handshake.

Top module: `quad_ref_div`

## Requirements
- R1: On any clock edge where `rst` is 1, the prescaler, the retiming stage and the ring counter clear. `phase_i`, `phase_q` and `wrap_stb` then read 0 in the next cycle, whatever `run_en` is.
- R2: The state {`phase_q`,`phase_i`} moves only in the order 00, 01, 11, 10, 00. When it changes, the new `phase_q` equals the old `phase_i`, and the new `phase_i` equals the inverse of the old `phase_q`.
- R3: With `run_en` held at 1, every ring state lasts exactly 32 enabled cycles. Each output therefore has a period of 128 cycles and is high for 64 of them.
- R4: `phase_q` repeats `phase_i` delayed by exactly 32 enabled cycles, so `phase_i` leads.
- R5: After reset is released with `run_en` at 1, `phase_i` first rises on the 18th enabled edge. That is 16 prescaler counts, plus one cycle for the retiming flop and one for the edge detector.
- R6: `wrap_stb` is high for exactly one cycle each time the state returns from 10 to 00. While it is high both outputs read 0. Successive strobes are 128 enabled cycles apart.
- R7: An edge with `run_en` at 0 changes no state. Both outputs hold, `wrap_stb` reads 0 in the next cycle, and the whole schedule shifts later by the number of disabled edges.
- R8: At most one of `phase_i` and `phase_q` changes on any edge. Both are driven directly by flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Advance enable; 0 freezes the chain |
| phase_i | output | 1 | In-phase square wave, reference/128 |
| phase_q | output | 1 | Quadrature square wave, lags by 32 enabled cycles |
| wrap_stb | output | 1 | One-cycle strobe when the ring returns to 00 |

## Verification
The bound checker covers the properties that hold on every edge:
- the legal ring successor and the single-bit change rule;
- the cleared state after reset;
- the freeze while the enable is low;
- the one-cycle width of the strobe and the all-zero outputs while it is high.

Absolute timing needs the bench's directed scenarios, which compare every cycle against an enabled-edge count. That covers the 18-edge start-up latency, the 32-cycle dwell, the 50% duty, the 32-cycle lag, the 128-cycle strobe spacing, the shift in schedule after a pause, and a reset in mid-run.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  localparam int unsigned PRE_DIV_DEF = 32;
  localparam int unsigned RING_W_DEF  = 2;

  function automatic int unsigned cnt_width(input int unsigned div);
    return (div <= 2) ? 1 : $clog2(div);
  endfunction
endpackage

// File: rtl/qdiv_prescaler.sv
module qdiv_prescaler #(
  parameter int unsigned DIV = qdiv_pkg::PRE_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic sq_out
);
  localparam int unsigned CW   = qdiv_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // High for the upper half of the count: 50% duty for even DIV.
  assign sq_out = (cnt >= HALF);
endmodule

// File: rtl/qdiv_retime.sv
module qdiv_retime (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic sq_in,
  output logic rise
);
  logic sync_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (adv) begin
      sync_q <= sq_in;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/qdiv_ring.sv
module qdiv_ring #(
  parameter int unsigned W = qdiv_pkg::RING_W_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic step,
  output logic tap_lead,
  output logic tap_lag,
  output logic wrap
);
  localparam int unsigned LAG_BIT = (W / 2 > 0) ? W / 2 : 1;
  localparam logic [W-1:0] TAIL  = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] st;
  logic         wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= adv & step & (st == TAIL);
      if (adv && step) begin
        st <= {st[W-2:0], ~st[W-1]};
      end
    end
  end

  assign tap_lead = st[0];
  assign tap_lag  = st[LAG_BIT];
  assign wrap     = wrap_q;
endmodule

// File: rtl/quad_ref_div.sv
module quad_ref_div #(
  parameter int unsigned PRE_DIV = qdiv_pkg::PRE_DIV_DEF,
  parameter int unsigned RING_W  = qdiv_pkg::RING_W_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic phase_i,
  output logic phase_q,
  output logic wrap_stb
);
  logic pre_sq;
  logic step;

  qdiv_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .adv(run_en), .sq_out(pre_sq)
  );

  qdiv_retime u_rt (
    .clk(clk), .rst(rst), .adv(run_en), .sq_in(pre_sq), .rise(step)
  );

  qdiv_ring #(.W(RING_W)) u_ring (
    .clk(clk), .rst(rst), .adv(run_en), .step(step),
    .tap_lead(phase_i), .tap_lag(phase_q), .wrap(wrap_stb)
  );
endmodule

// File: rtl/quad_ref_div_chk.sv
module quad_ref_div_chk (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic phase_i,
  input logic phase_q,
  input logic wrap_stb
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!phase_i && !phase_q && !wrap_stb));

  // R2
  ring_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable({phase_q, phase_i})) |->
      (phase_q == $past(phase_i) && phase_i == !$past(phase_q)));

  // R8
  single_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones({phase_i ^ $past(phase_i), phase_q ^ $past(phase_q)}) <= 1));

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_stb |=> !wrap_stb);

  // R6
  strobe_state_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_stb |-> (!phase_i && !phase_q));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !run_en) |=> ($stable({phase_i, phase_q}) && !wrap_stb));
endmodule

bind quad_ref_div quad_ref_div_chk u_chk (
  .clk(clk), .rst(rst), .run_en(run_en),
  .phase_i(phase_i), .phase_q(phase_q), .wrap_stb(wrap_stb)
);

// File: tb/quad_ref_div_tb.sv
module quad_ref_div_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic phase_i, phase_q, wrap_stb;

  int n_chk = 0;
  int n_fail = 0;
  int ek = 0;      // enabled edges since last reset
  logic en_seen;   // run_en value at the last edge

  always #2 clk = ~clk;

  quad_ref_div u_dut (
    .clk(clk), .rst(rst), .run_en(run_en),
    .phase_i(phase_i), .phase_q(phase_q), .wrap_stb(wrap_stb)
  );

  function automatic logic [1:0] exp_qi(input int k);
    logic [1:0] seq [4];
    seq[0] = 2'b01; seq[1] = 2'b11; seq[2] = 2'b10; seq[3] = 2'b00;
    if (k < 18) return 2'b00;
    return seq[((k - 18) / 32) % 4];
  endfunction

  function automatic logic exp_wrap(input int k, input logic en);
    return en && (k >= 114) && ((k - 114) % 128 == 0);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at ek=%0d: {q,i,stb} actual=%b expected=%b", req, ek, act, exp);
    end
  endtask

  task automatic tick();
    en_seen = run_en;
    @(posedge clk);
    #1;
    if (!rst && en_seen) ek++;
  endtask

  task automatic compare_now(input string req);
    check(req, {phase_q, phase_i, wrap_stb}, {exp_qi(ek), exp_wrap(ek, en_seen)});
  endtask

  task automatic do_reset();
    rst = 1'b1; run_en = 1'b1;
    tick(); tick();
    ek = 0;
    check("R1", {phase_q, phase_i, wrap_stb}, 3'b000);
    rst = 1'b0;
  endtask

  // R5, R2, R6: start-up and one full run
  task automatic t_startup();
    do_reset();
    for (int c = 0; c < 400; c++) begin
      tick();
      if (ek == 17) check("R5", {2'b0, phase_i}, 3'b000);
      if (ek == 18) check("R5", {2'b0, phase_i}, 3'b001);
      compare_now((ek == 114 || ek == 242) ? "R6" : "R2");
    end
  endtask

  // R3, R4: dwell, duty and lag measured on the outputs
  task automatic t_duty_lag();
    int hi_i = 0, hi_q = 0, ri = -1, rq = -1;
    logic pi, pq;
    do_reset();
    while (ek < 200) tick();
    pi = phase_i; pq = phase_q;
    for (int c = 0; c < 128; c++) begin
      tick();
      if (phase_i) hi_i++;
      if (phase_q) hi_q++;
      if (phase_i && !pi) ri = ek;
      if (phase_q && !pq && ri >= 0 && rq < 0) rq = ek;
      pi = phase_i; pq = phase_q;
    end
    check("R3", {1'b0, hi_i[1:0] == 0 && hi_i == 64, 1'b1}, 3'b011);
    check("R3", {1'b0, hi_q == 64, 1'b1}, 3'b011);
    check("R4", {1'b0, (rq - ri) == 32, 1'b1}, 3'b011);
  endtask

  // R7: pause mid-run, including right before a step and a wrap
  task automatic t_pause();
    logic [1:0] held;
    do_reset();
    while (ek < 113) tick();
    held = {phase_q, phase_i};
    run_en = 1'b0;
    for (int c = 0; c < 21; c++) begin
      tick();
      check("R7", {phase_q, phase_i, wrap_stb}, {held, 1'b0});
    end
    run_en = 1'b1;
    for (int c = 0; c < 300; c++) begin
      tick();
      compare_now("R7");
    end
  endtask

  // R1: reset in the middle of a run with the enable high
  task automatic t_mid_reset();
    do_reset();
    while (ek < 90) tick();
    rst = 1'b1;
    tick();
    check("R1", {phase_q, phase_i, wrap_stb}, 3'b000);
    ek = 0;
    rst = 1'b0;
    for (int c = 0; c < 150; c++) begin
      tick();
      compare_now("R1");
    end
  endtask

  initial begin
    fork
      begin
        t_startup();
        t_duty_lag();
        t_pause();
        t_mid_reset();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule